// File: doc/BRIEF.md
# FIFO Port Width Adapter

This block sits at one port of a wide FIFO and changes the width of the data seen there. Inside, a word is 72 bits wide and is treated as four 18-bit lanes. Lane A is bits 71:54, lane B is bits 53:36, lane C is bits 35:18 and lane D is bits 17:0. Outside, the port can stay 72 bits wide, or it can carry 36-bit or 18-bit words. The adapter either splits one wide word into several narrow reads, or gathers several narrow writes into one wide word. A configuration input picks big-endian or little-endian lane order.

Four static configuration pins select the mode:

- `cfg_match_en` turns bus matching on. When it is low, the other three pins are ignored and data passes straight through at full width.
- `cfg_narrow_in` picks the direction. Low means a wide input with a narrow output (splitting). High means a narrow input with a wide output (packing).
- `cfg_narrow_18` picks the narrow width. Low means 36 bits and high means 18 bits.
- `cfg_big_end` picks the lane order.

The configuration must only change while reset is held.

Both data sides use valid/ready handshakes. A beat moves when valid and ready are both high at a rising clock edge. A source must keep its valid and data steady until ready is seen. When splitting, the wide input word stays in place (it is not popped) until its last narrow piece has been taken, so back-pressure on the output stalls the input. When packing, a finished wide word is held stable until it is taken. While it waits, new narrow writes are refused, unless the output is being drained in the same cycle.

Top module: `fifo_width_adapter`

## Requirements
- R1: With `cfg_match_en` low, `out_data` equals `in_data`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle, whatever the values of the other three configuration pins.
- R2: Narrow data always sits in the low bits of its port. A 36-bit word uses bits 35:0 and an 18-bit word uses bits 17:0. When splitting, the unused upper bits of `out_data` are zero.
- R3: Splitting to 36 bits in big-endian order (`cfg_narrow_in`=0, `cfg_narrow_18`=0, `cfg_big_end`=1): the first read carries lanes A and B as {A,B}, and the second carries {C,D}.
- R4: Splitting to 36 bits in little-endian order: the first read carries {C,D} and the second carries {A,B}.
- R5: Splitting to 18 bits (`cfg_narrow_18`=1) in big-endian order delivers lanes A, B, C, D in that order.
- R6: Splitting to 18 bits in little-endian order delivers lanes D, C, B, A in that order.
- R7: Packing from 36 bits (`cfg_narrow_in`=1, `cfg_narrow_18`=0): in big-endian order the first write fills {A,B} and the second fills {C,D}. In little-endian order the first write fills {C,D} and the second fills {A,B}. Input bits 71:36 are ignored.
- R8: Packing from 18 bits: in big-endian order the writes fill A, B, C, D in turn. In little-endian order they fill D, C, B, A in turn. Input bits 71:18 are ignored.
- R9: When splitting, `in_ready` is high only in a cycle where the last narrow piece of the current word is being offered and `out_ready` is high. The input word is popped only then.
- R10: When packing, `out_valid` rises only after every narrow write of the group has been accepted. While it is not taken, `out_data` stays stable and `in_ready` is low.
- R11: Reset returns the piece counter to the first narrow piece and, when packing, clears `out_valid` and raises `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_big_end | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| cfg_match_en | input | 1 | 1 = width conversion enabled, 0 = straight pass-through |
| cfg_narrow_in | input | 1 | 1 = narrow input packed to wide output, 0 = wide input split to narrow output |
| cfg_narrow_18 | input | 1 | 1 = narrow side is 18 bits, 0 = narrow side is 36 bits |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted at this edge when valid is high |
| in_data | input | 72 | Input data; a narrow word uses the low bits |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Downstream can take the output beat |
| out_data | output | 72 | Output data; a narrow word uses the low bits |

## Verification
The bench targets the lane order in all four split modes and all four pack modes. A design with a swapped slot index would hand out lanes in mirrored order, or would pack lanes into the wrong quarter. Narrow inputs carry random garbage in their upper bits, so a packer that reads past the narrow width corrupts the wide word.

Back-pressure is checked in two ways:

- A design that pops the wide input early would lose the remaining pieces.
- A packer that keeps accepting writes while its full word is stalled would overwrite lanes before they are read.

Pass-through is run under two different settings of the ignored configuration pins.

// File: rtl/fwa_pkg.sv
package fwa_pkg;
  typedef enum logic [1:0] {
    XFER_PASS   = 2'd0,
    XFER_SPLIT  = 2'd1,
    XFER_GATHER = 2'd2
  } xfer_mode_e;

  // Physical slot for a given beat number of a group.
  // Big-endian walks the slots from the most significant end;
  // little-endian walks them from the least significant end.
  function automatic logic [1:0] slot_of(input logic [1:0] phase,
                                         input logic       big,
                                         input logic       n18);
    logic [1:0] top;
    top = n18 ? 2'd3 : 2'd1;
    return big ? phase : (top - phase);
  endfunction

  // High on the final beat of a group: beat 3 for 18-bit, beat 1 for 36-bit.
  function automatic logic phase_last(input logic [1:0] phase,
                                      input logic       n18);
    return phase == (n18 ? 2'd3 : 2'd1);
  endfunction
endpackage

// File: rtl/fwa_mode_decode.sv
module fwa_mode_decode
  import fwa_pkg::*;
(
  input  logic       cfg_match_en,
  input  logic       cfg_narrow_in,
  output xfer_mode_e mode
);
  always_comb begin
    if (!cfg_match_en)     mode = XFER_PASS;
    else if (cfg_narrow_in) mode = XFER_GATHER;
    else                    mode = XFER_SPLIT;
  end
endmodule

// File: rtl/fwa_split.sv
module fwa_split
  import fwa_pkg::*;
#(
  parameter int LANE_W = 18,
  localparam int LANES = 4,
  localparam int WIDE_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              big,
  input  logic              n18,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIDE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_data
);
  logic [LANE_W-1:0] lane [LANES];
  logic [1:0]        phase_q;
  logic [1:0]        slot;
  logic              last;

  // Lane 0 is the most significant quarter of the wide word.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = in_data[WIDE_W-1-k*LANE_W -: LANE_W];
  end

  assign slot      = slot_of(phase_q, big, n18);
  assign last      = phase_last(phase_q, n18);
  assign out_valid = active && in_valid;
  // The wide word is popped only with its last piece.
  assign in_ready  = active && out_ready && last;

  always_comb begin
    out_data = '0;
    if (n18) out_data[LANE_W-1:0] = lane[slot];
    else     out_data[2*LANE_W-1:0] = {lane[{slot[0], 1'b0}], lane[{slot[0], 1'b1}]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (out_valid && out_ready) begin
      phase_q <= last ? 2'd0 : phase_q + 2'd1;
    end
  end
endmodule

// File: rtl/fwa_gather.sv
module fwa_gather
  import fwa_pkg::*;
#(
  parameter int LANE_W = 18,
  localparam int LANES = 4,
  localparam int WIDE_W = LANES * LANE_W,
  localparam int NAR_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              big,
  input  logic              n18,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NAR_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_data
);
  logic [LANE_W-1:0] acc_q [LANES];
  logic [LANES-1:0]  lane_we;
  logic [1:0]        phase_q;
  logic [1:0]        slot;
  logic              full_q;
  logic              in_fire;
  logic              last;

  assign slot      = slot_of(phase_q, big, n18);
  assign last      = phase_last(phase_q, n18);
  assign out_valid = active && full_q;
  // A full word blocks new writes unless it is being drained this cycle.
  assign in_ready  = active && (!full_q || out_ready);
  assign in_fire   = in_valid && in_ready;

  always_comb begin
    lane_we = '0;
    if (in_fire) begin
      if (n18) lane_we[slot] = 1'b1;
      else begin
        lane_we[{slot[0], 1'b0}] = 1'b1;
        lane_we[{slot[0], 1'b1}] = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_acc
    logic [LANE_W-1:0] wr_val;
    // In 36-bit mode the upper half of the narrow word goes to the even lane.
    if (k % 2 == 0) begin : g_even
      assign wr_val = n18 ? in_data[LANE_W-1:0] : in_data[NAR_W-1:LANE_W];
    end else begin : g_odd
      assign wr_val = in_data[LANE_W-1:0];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)          acc_q[k] <= '0;
      else if (lane_we[k]) acc_q[k] <= wr_val;
    end
    assign out_data[WIDE_W-1-k*LANE_W -: LANE_W] = acc_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      full_q  <= 1'b0;
    end else begin
      if (in_fire) phase_q <= last ? 2'd0 : phase_q + 2'd1;
      if (in_fire && last)            full_q <= 1'b1;
      else if (out_valid && out_ready) full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_width_adapter.sv
module fifo_width_adapter
  import fwa_pkg::*;
#(
  parameter int LANE_W = 18,
  localparam int WIDE_W = 4 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_end,
  input  logic              cfg_match_en,
  input  logic              cfg_narrow_in,
  input  logic              cfg_narrow_18,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIDE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_data
);
  xfer_mode_e        mode;
  logic              sp_in_ready, sp_out_valid;
  logic [WIDE_W-1:0] sp_out_data;
  logic              ga_in_ready, ga_out_valid;
  logic [WIDE_W-1:0] ga_out_data;

  fwa_mode_decode u_dec (
    .cfg_match_en (cfg_match_en),
    .cfg_narrow_in(cfg_narrow_in),
    .mode         (mode)
  );

  fwa_split #(.LANE_W(LANE_W)) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (mode == XFER_SPLIT),
    .big      (cfg_big_end),
    .n18      (cfg_narrow_18),
    .in_valid (in_valid),
    .in_ready (sp_in_ready),
    .in_data  (in_data),
    .out_valid(sp_out_valid),
    .out_ready(out_ready),
    .out_data (sp_out_data)
  );

  fwa_gather #(.LANE_W(LANE_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (mode == XFER_GATHER),
    .big      (cfg_big_end),
    .n18      (cfg_narrow_18),
    .in_valid (in_valid),
    .in_ready (ga_in_ready),
    .in_data  (in_data[2*LANE_W-1:0]),
    .out_valid(ga_out_valid),
    .out_ready(out_ready),
    .out_data (ga_out_data)
  );

  always_comb begin
    unique case (mode)
      XFER_SPLIT: begin
        in_ready  = sp_in_ready;
        out_valid = sp_out_valid;
        out_data  = sp_out_data;
      end
      XFER_GATHER: begin
        in_ready  = ga_in_ready;
        out_valid = ga_out_valid;
        out_data  = ga_out_data;
      end
      default: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
    endcase
  end
endmodule

// File: rtl/fwa_checker.sv
module fwa_checker #(
  parameter int LANE_W = 18,
  localparam int WIDE_W = 4 * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_big_end,
  input logic              cfg_match_en,
  input logic              cfg_narrow_in,
  input logic              cfg_narrow_18,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WIDE_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WIDE_W-1:0] out_data
);
  logic splitting, gathering, upper_clear;
  assign splitting   = cfg_match_en && !cfg_narrow_in;
  assign gathering   = cfg_match_en && cfg_narrow_in;
  assign upper_clear = cfg_narrow_18 ? (out_data[WIDE_W-1:LANE_W] == '0)
                                     : (out_data[WIDE_W-1:2*LANE_W] == '0);

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_match_en |-> (out_data == in_data && out_valid == in_valid
                       && in_ready == out_ready && (cfg_big_end || !cfg_big_end)));  // R1
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (splitting && out_valid) |-> upper_clear);  // R2
  AST_SPLIT_POP_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    (splitting && in_ready) |-> out_ready);  // R9
  AST_GATHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gathering && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R10
  AST_GATHER_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (gathering && out_valid && !out_ready) |-> !in_ready);  // R10
endmodule

bind fifo_width_adapter fwa_checker #(.LANE_W(LANE_W)) u_fwa_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_big_end  (cfg_big_end),
  .cfg_match_en (cfg_match_en),
  .cfg_narrow_in(cfg_narrow_in),
  .cfg_narrow_18(cfg_narrow_18),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data)
);

// File: tb/fifo_width_adapter_tb.sv
module fifo_width_adapter_tb_top;
  localparam int W = 72;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_big_end = 1'b0, cfg_match_en = 1'b0;
  logic         cfg_narrow_in = 1'b0, cfg_narrow_18 = 1'b0;
  logic         in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, out_valid;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fifo_width_adapter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_big_end(cfg_big_end), .cfg_match_en(cfg_match_en),
    .cfg_narrow_in(cfg_narrow_in), .cfg_narrow_18(cfg_narrow_18),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rand72();
    return {8'($urandom), $urandom, $urandom};
  endfunction

  // Narrow piece p of wide word w, right-aligned with zero upper bits.
  function automatic logic [W-1:0] piece(input logic [W-1:0] w, input bit big,
                                         input bit n18, input int p);
    int n = n18 ? 4 : 2;
    int s = big ? p : n - 1 - p;
    logic [W-1:0] r = '0;
    if (n18) r[17:0] = w[71-18*s -: 18];
    else     r[35:0] = w[71-36*s -: 36];
    return r;
  endfunction

  task automatic do_reset(input bit big, input bit bm, input bit nin, input bit n18);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    cfg_big_end = big; cfg_match_en = bm; cfg_narrow_in = nin; cfg_narrow_18 = n18;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Random traffic in one mode; the expected stream comes from piece().
  task automatic run_mode(input bit big, input bit bm, input bit nin, input bit n18,
                          input int groups, input string req);
    logic [W-1:0] src[$];
    logic [W-1:0] expq[$];
    int n = n18 ? 4 : 2;
    int sent = 0;
    int guard = 0;
    bit took = 1'b1;
    do_reset(big, bm, nin, n18);
    for (int g = 0; g < groups; g++) begin
      logic [W-1:0] w = rand72();
      if (!bm) begin
        src.push_back(w); expq.push_back(w);
      end else if (!nin) begin
        src.push_back(w);
        for (int p = 0; p < n; p++) expq.push_back(piece(w, big, n18, p));
      end else begin
        logic [W-1:0] mask = n18 ? {{54{1'b0}}, {18{1'b1}}} : {{36{1'b0}}, {36{1'b1}}};
        for (int p = 0; p < n; p++)
          src.push_back(piece(w, big, n18, p) | (rand72() & ~mask));
        expq.push_back(w);
      end
    end
    while ((expq.size() != 0) && guard < 20000) begin
      guard++;
      @(negedge clk);
      if (!in_valid || took) begin
        if (sent < src.size() && ($urandom % 4) != 0) begin
          in_valid = 1'b1; in_data = src[sent];
        end else begin
          in_valid = 1'b0; in_data = rand72();
        end
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      if (out_valid && out_ready) check(req, out_data, expq.pop_front());
      took = in_valid && in_ready;
      if (took) sent++;
    end
    check({req, " drained"}, W'(expq.size()), '0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0072));
    // Pass-through with two different settings of the ignored pins.
    run_mode(1'b1, 1'b0, 1'b1, 1'b0, 30, "R1");
    run_mode(1'b0, 1'b0, 1'b0, 1'b1, 30, "R1");
    run_mode(1'b1, 1'b1, 1'b0, 1'b0, 30, "R3");
    run_mode(1'b0, 1'b1, 1'b0, 1'b0, 30, "R4");
    run_mode(1'b1, 1'b1, 1'b0, 1'b1, 30, "R5");
    run_mode(1'b0, 1'b1, 1'b0, 1'b1, 30, "R6");
    run_mode(1'b1, 1'b1, 1'b1, 1'b0, 30, "R7");
    run_mode(1'b0, 1'b1, 1'b1, 1'b0, 30, "R7");
    run_mode(1'b1, 1'b1, 1'b1, 1'b1, 30, "R8");
    run_mode(1'b0, 1'b1, 1'b1, 1'b1, 30, "R8");

    // R11: reset state in gather mode.
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    #1;
    check("R11 out_valid", W'(out_valid), '0);
    check("R11 in_ready", W'(in_ready), W'(1));

    // R10: fill a group with the sink stalled, then hold.
    begin
      logic [W-1:0] w = rand72();
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = piece(w, 1'b1, 1'b1, p); out_ready = 1'b0;
        #1;
        check("R10 out_valid low before group done", W'(out_valid), '0);
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = rand72();
      for (int c = 0; c < 3; c++) begin
        #1;
        check("R10 out_valid held", W'(out_valid), W'(1));
        check("R10 in_ready low while stalled", W'(in_ready), '0);
        check("R10 data stable", out_data, w);
        @(negedge clk);
      end
      in_valid = 1'b0; out_ready = 1'b1;
      @(negedge clk);
      #1;
      check("R10 out_valid drops after take", W'(out_valid), '0);
    end

    // R9 / R11 / R2: split to 18 bits big-endian, sink always ready.
    do_reset(1'b1, 1'b1, 1'b0, 1'b1);
    begin
      logic [W-1:0] w = rand72();
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = w; out_ready = 1'b1;
        #1;
        check("R9 in_ready only on last piece", W'(in_ready), W'(p == 3));
        check("R11 R2 piece order after reset", out_data, piece(w, 1'b1, 1'b1, p));
      end
      // R9: stalled sink never pops.
      @(negedge clk);
      out_ready = 1'b0;
      #1;
      check("R9 in_ready low with sink stalled", W'(in_ready), '0);
      check("R9 first piece of next word", out_data, piece(w, 1'b1, 1'b1, 0));
      @(negedge clk);
      in_valid = 1'b0;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule